// File: doc/BRIEF.md
# Scrambled-Address Banked RAM

This block is a 64-word single-port RAM assembled from eight banks of eight words each. A 6-bit address is split into two fields. Three address bits choose the bank. The other three bits give the word inside that bank. Which address bits make up the bank field is a parameter. Each bank also applies its own fixed reordering to its three offset bits before indexing its storage.

Seen from the ports, none of this scrambling is visible. The storage mapping is one-to-one, and the bank field that gates the write strobe is the same field that steers the read multiplexer. As a result, every configuration behaves exactly like a flat 64-entry array.

Writes are synchronous to the rising clock edge. Reads are combinational from the current address. A configuration that reuses an address bit, or that gives a bank an offset reordering which is not a true permutation, stops elaboration with an error.

Top module: `scrambled_ram`

## Requirements
- R1: On a rising clock edge with `wr_en` high, `wr_data` is stored at `addr`. From then on, `rd_data` returns that value whenever `addr` selects that word, starting in the cycle after the edge.
- R2: `rd_data` is combinational. A change on `addr` is reflected on `rd_data` before the next clock edge, with no clock edge needed.
- R3: A rising edge with `wr_en` low changes no stored word.
- R4: A write alters only the addressed word. All other 63 words keep their values.
- R5: At most one bank receives a write strobe per edge, and no bank receives one while `wr_en` is low.
- R6: The bank field is given by parameters `BANK_BIT0..2`, where BANK_BIT0 is the least significant select bit. With the default (bits 5,4,3), the lowest-bits choice (0,1,2) and a middle choice (2,3,4), the block matches a flat 64-word array under mixed random traffic.
- R7: Per-bank offset reordering is given by `OFS_PERM`, 6 bits per bank with bank 0 in bits 5:0. Bank-internal index bit k comes from remaining-offset bit `OFS_PERM[6*b+2*k +: 2]`, where the remaining bits are numbered in ascending address order. With all 64 words written with distinct values, every word reads back its own value, so no two addresses share storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock, rising edge |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 6 | Word address for both read and write |
| wr_data | input | DW | Data to store |
| rd_data | output | DW | Word currently addressed (combinational) |

## Verification
The assertions assume that `addr`, `wr_en` and `wr_data` are settled around each rising edge. They also assume that stored contents are meaningful only after they have been written, since the block has no reset. The bench therefore drives all inputs on the falling edge. It fills every word before comparing against its flat model, so no check ever reads an unwritten word. Three instances with different bank-field choices and reorderings share one stimulus stream and are all compared with the same model.

// File: rtl/scrambled_ram.sv
module scrambled_ram #(
  parameter int DW = 8,
  parameter int BANK_BIT0 = 3,
  parameter int BANK_BIT1 = 4,
  parameter int BANK_BIT2 = 5,
  parameter logic [47:0] OFS_PERM = {6'h09, 6'h18, 6'h06, 6'h12, 6'h09, 6'h21, 6'h18, 6'h24}
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [5:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int AW = 6;
  localparam int NB = 8;
  localparam int NW = 8;

  function automatic int free_bit(input int n);
    int cnt = 0;
    int pos = 0;
    for (int i = 0; i < AW; i++) begin
      if (i != BANK_BIT0 && i != BANK_BIT1 && i != BANK_BIT2) begin
        if (cnt == n) pos = i;
        cnt++;
      end
    end
    return pos;
  endfunction

  function automatic bit cfg_ok();
    bit ok = 1'b1;
    if (BANK_BIT0 < 0 || BANK_BIT0 >= AW) ok = 1'b0;
    if (BANK_BIT1 < 0 || BANK_BIT1 >= AW) ok = 1'b0;
    if (BANK_BIT2 < 0 || BANK_BIT2 >= AW) ok = 1'b0;
    if (BANK_BIT0 == BANK_BIT1 || BANK_BIT0 == BANK_BIT2 || BANK_BIT1 == BANK_BIT2) ok = 1'b0;
    for (int b = 0; b < NB; b++) begin
      logic [3:0] seen = '0;
      for (int k = 0; k < 3; k++) seen[OFS_PERM[6*b+2*k +: 2]] = 1'b1;
      if (seen != 4'b0111) ok = 1'b0;
    end
    return ok;
  endfunction

  localparam bit CFG_OK = cfg_ok();
  localparam int FB0 = free_bit(0);
  localparam int FB1 = free_bit(1);
  localparam int FB2 = free_bit(2);

  if (!CFG_OK) begin : g_bad_cfg
    $error("scrambled_ram: bank bits overlap or offset reordering is not a permutation");
  end

  logic [2:0]    bank_sel;
  logic [2:0]    ofs_raw;
  logic [NB-1:0] bank_we;
  logic [DW-1:0] bank_rd [NB];

  assign bank_sel = {addr[BANK_BIT2], addr[BANK_BIT1], addr[BANK_BIT0]};
  assign ofs_raw  = {addr[FB2], addr[FB1], addr[FB0]};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0] store [NW];
    logic [2:0]    idx;

    for (genvar k = 0; k < 3; k++) begin : g_bit
      assign idx[k] = ofs_raw[OFS_PERM[6*b+2*k +: 2]];
    end

    assign bank_we[b] = wr_en && (bank_sel == 3'(b));
    assign bank_rd[b] = store[idx];

    always_ff @(posedge clk) begin
      if (bank_we[b]) store[idx] <= wr_data;
    end
  end

  assign rd_data = bank_rd[bank_sel];
endmodule

module scrambled_ram_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          wr_en,
  input logic [5:0]    addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_data,
  input logic [7:0]    bank_we
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  // R5
  one_bank_chk: assert property (@(posedge clk) disable iff (!armed) $onehot0(bank_we));

  // R5
  idle_bank_chk: assert property (@(posedge clk) disable iff (!armed) !wr_en |-> bank_we == '0);

  // R1
  write_read_chk: assert property (@(posedge clk) disable iff (!armed)
    wr_en |=> (addr != $past(addr)) || (rd_data == $past(wr_data)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!armed)
    !wr_en |=> (addr != $past(addr)) || $stable(rd_data));
endmodule

bind scrambled_ram scrambled_ram_chk #(.DW(DW)) u_chk (
  .clk(clk), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .bank_we(bank_we)
);

// File: tb/test_scrambled_ram.sv
`timescale 1ns/1ps
module test_scrambled_ram;
  localparam int DW = 8;
  logic          clk = 1'b0;
  logic          wr_en = 1'b0;
  logic [5:0]    addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_hi, rd_lo, rd_mid;
  logic [DW-1:0] model [64];
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  scrambled_ram #(.DW(DW)) i_scrambled_ram (
    .clk(clk), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_hi));

  scrambled_ram #(.DW(DW), .BANK_BIT0(0), .BANK_BIT1(1), .BANK_BIT2(2),
    .OFS_PERM({6'h24, 6'h06, 6'h12, 6'h09, 6'h21, 6'h18, 6'h24, 6'h06})) i_scrambled_ram_lo (
    .clk(clk), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_lo));

  scrambled_ram #(.DW(DW), .BANK_BIT0(3), .BANK_BIT1(2), .BANK_BIT2(4),
    .OFS_PERM({6'h18, 6'h21, 6'h09, 6'h12, 6'h06, 6'h24, 6'h09, 6'h12})) i_scrambled_ram_mid (
    .clk(clk), .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_mid));

  task automatic check(input string req, input logic [DW-1:0] exp);
    total++;
    if (rd_hi !== exp || rd_lo !== exp || rd_mid !== exp) begin
      bad++;
      $display("FAIL %s addr=%0d actual hi=%h lo=%h mid=%h expected=%h",
               req, addr, rd_hi, rd_lo, rd_mid, exp);
    end
  endtask

  task automatic write_word(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    model[a] = d;
    #1;
  endtask

  task automatic idle_edge(input logic [5:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = a; wr_data = d;
    @(posedge clk);
    #1;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      wr_en = 1'b0; addr = 6'(a);
      #1;
      check(req, model[a]);
    end
  endtask

  // R7 R1: distinct fill, everything reads back its own value
  task automatic t_fill;
    for (int a = 0; a < 64; a++) write_word(6'(a), DW'(a * 3 + 17));
    sweep("R7");
    write_word(6'd21, 8'hA5);
    check("R1", 8'hA5);
  endtask

  // R2: address change visible without a clock edge
  task automatic t_comb;
    @(negedge clk);
    wr_en = 1'b0; addr = 6'd9;
    #0.5;
    check("R2", model[9]);
    addr = 6'd54;
    #0.5;
    check("R2", model[54]);
    addr = 6'd0;
    #0.5;
    check("R2", model[0]);
  endtask

  // R3: idle edges with changing data store nothing
  task automatic t_idle;
    for (int i = 0; i < 16; i++) idle_edge(6'(i * 4 + 1), 8'hFF - 8'(i));
    sweep("R3");
  endtask

  // R4: one write, 63 neighbours untouched
  task automatic t_isolate;
    write_word(6'd63, 8'h3C);
    write_word(6'd0, 8'hC3);
    sweep("R4");
  endtask

  // R6 R5: random mixed traffic on all three configurations
  task automatic t_random;
    for (int i = 0; i < 600; i++) begin
      logic [5:0] a;
      a = 6'($urandom_range(0, 63));
      if ($urandom_range(0, 2) == 0) begin
        write_word(a, 8'($urandom));
      end else begin
        idle_edge(a, 8'($urandom));
        check("R6", model[a]);
      end
    end
    sweep("R6");
  endtask

  initial begin
    #100000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(posedge clk);
    t_fill();
    t_comb();
    t_idle();
    t_isolate();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule